// File: doc/BRIEF.md
# Width-Selectable Serial Transmitter

This block turns a parallel word into a serial bit stream, sending either 8 or 16 bits per frame. A mode input chooses the frame width when the frame starts. While the block is idle, a write strobe copies a 16-bit bus word into two chained 8-bit shift stages. The output stage holds the low byte and the upper stage holds the high byte. A start request then launches the frame. Bits leave least significant first on one serial pin, and each bit advances only in a system-clock cycle where the shift-clock enable is high.

In wide mode the upper stage shifts into the output stage, so the high byte follows the low byte. In narrow mode that link is cut. Zeros refill the output stage, and the upper stage keeps its contents. A bit-position counter uses three bits in narrow mode and four in wide mode, and it ends the frame. After the last bit has been held for one full shift period, the next shift tick returns the pin to 0, drops busy and raises a one-clock done pulse.

Top module: `wsel_serial_tx`

## Requirements
- R1: After reset, ser_out, busy and done are all 0.
- R2: With mode_wide=1 at the start, a frame carries 16 bits: wr_data[0] first through wr_data[15] last, with bits 15:8 arriving after bits 7:0 (16'h7234 gives 0010110001001110).
- R3: With mode_wide=0 at the start, a frame carries only bits 7:0, LSB first (16'h7234 gives 00101100). Zeros refill the output stage and the upper stage is left untouched. A later wide frame sent without a new write therefore carries eight 0 bits followed by the retained upper byte.
- R4: ser_out changes only at the rising clock edge of a cycle in which shift_en is 1. Bit k of a frame appears at the (k+1)-th such edge after the start is accepted.
- R5: A start_req seen while idle sets busy at the next clock edge. ser_out stays 0 until the first shift tick, and the internal start flag clears on that tick.
- R6: busy stays 1 until the final bit has been held for one shift period. The next shift tick clears busy and ser_out, and done is 1 for exactly one clock after that edge.
- R7: A write seen while idle loads the shift stages. A write seen while busy is ignored and does not alter the bits still to be sent.
- R8: A start_req seen while busy is ignored. The frame keeps its length and its content.
- R9: The width is sampled when the start is accepted. A change of mode_wide during a frame has no effect on that frame.
- R10: ser_out is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_en | input | 1 | One-cycle enable marking a shift-clock edge |
| mode_wide | input | 1 | 1 selects 16-bit frames, 0 selects 8-bit frames |
| wr_strobe | input | 1 | Parallel load request |
| wr_data | input | 16 | Parallel word to send |
| start_req | input | 1 | Frame start request |
| ser_out | output | 1 | Serial data, LSB first |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse when a frame ends |

## Verification
Some properties hold on every cycle, and the in-module assertions check those. The pin is quiet while the block is idle. The output holds between shift ticks. Done lasts a single clock. The start flag clears on the first tick. The bit counter never passes the last position for the latched width. The upper stage holds still during narrow frames. Other behaviours only show up across a whole scenario, and the bench covers those: the exact LSB-first order for both widths, the point where a frame ends, the refill-with-zeros effect seen on a later unloaded frame, and the frame staying intact when writes, starts and mode flips arrive in the middle of it.

// File: rtl/wsel_tx_pkg.sv
package wsel_tx_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SEND, PH_TAIL} phase_t;

  // number of bits carried by one frame for the chosen width
  function automatic int unsigned frame_bits(input int unsigned stage_w,
                                             input int unsigned n_stg,
                                             input logic wide);
    return wide ? stage_w * n_stg : stage_w;
  endfunction
endpackage

// File: rtl/wsel_bit_counter.sv
module wsel_bit_counter #(
  parameter int unsigned STAGE_W = 8,
  parameter int unsigned N_STG   = 2,
  localparam int unsigned CNT_W  = $clog2(STAGE_W * N_STG)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic wide,
  output logic at_last
);
  import wsel_tx_pkg::*;

  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] last_pos;

  always_comb last_pos = CNT_W'(frame_bits(STAGE_W, N_STG, wide) - 1);
  assign at_last = (pos_q == last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos_q <= '0;
    else if (step)     pos_q <= at_last ? '0 : pos_q + 1'b1;
  end

  // R2 / R3: position never exceeds the last index of the latched width
  p_pos_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= last_pos);
endmodule

// File: rtl/wsel_shift_chain.sv
module wsel_shift_chain #(
  parameter int unsigned STAGE_W = 8,
  parameter int unsigned N_STG   = 2,
  localparam int unsigned BUS_W  = STAGE_W * N_STG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUS_W-1:0] load_word,
  input  logic             tick,
  input  logic             flush,
  input  logic             wide,
  output logic             ser_q
);
  logic [N_STG-1:0] lsb;
  logic [N_STG-1:0] fill;
  logic [N_STG-1:0] run;

  for (genvar g = 0; g < N_STG; g++) begin : g_stage
    logic [STAGE_W-1:0] q;

    if (g == N_STG - 1) begin : g_top
      assign fill[g] = 1'b0;
    end else begin : g_link
      assign fill[g] = wide & lsb[g+1];
    end

    if (g == 0) begin : g_out
      assign run[g] = tick;
    end else begin : g_up
      assign run[g] = tick & wide;
    end

    assign lsb[g] = q[0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (load)   q <= load_word[g*STAGE_W +: STAGE_W];
      else if (run[g]) q <= {fill[g], q[STAGE_W-1:1]};
    end

    if (g > 0) begin : g_chk
      // R3: upper stages keep their content during narrow frames
      p_upper_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wide) |=> $stable(q));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ser_q <= 1'b0;
    else if (flush) ser_q <= 1'b0;
    else if (tick)  ser_q <= lsb[0];
  end

  // R4: output moves only on a shift tick or the frame-end flush
  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !flush) |=> $stable(ser_q));
endmodule

// File: rtl/wsel_tx_ctrl.sv
module wsel_tx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_strobe,
  input  logic start_req,
  input  logic shift_en,
  input  logic mode_in,
  input  logic at_last,
  output logic load,
  output logic tick,
  output logic flush,
  output logic mode_q,
  output logic busy,
  output logic done
);
  import wsel_tx_pkg::*;

  phase_t phase;
  logic   start_flag;

  assign busy  = (phase != PH_IDLE);
  assign load  = wr_strobe & (phase == PH_IDLE);
  assign tick  = shift_en & (phase == PH_SEND);
  assign flush = shift_en & (phase == PH_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      start_flag <= 1'b0;
      mode_q     <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start_req) begin
          phase      <= PH_SEND;
          mode_q     <= mode_in;
          start_flag <= 1'b1;
        end
        PH_SEND: if (shift_en) begin
          start_flag <= 1'b0;
          if (at_last) phase <= PH_TAIL;
        end
        PH_TAIL: if (shift_en) begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R5: the start flag clears itself on the first shift tick
  p_start_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_flag && shift_en) |=> !start_flag);
  // R6: done is a single-clock pulse
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: done only follows the tail period
  p_done_after_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == PH_IDLE) && $past(phase == PH_TAIL));
  // R9: latched width stays fixed while a frame runs
  p_mode_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));
endmodule

// File: rtl/wsel_serial_tx.sv
module wsel_serial_tx #(
  parameter int unsigned STAGE_W = 8,
  parameter int unsigned N_STG   = 2,
  localparam int unsigned BUS_W  = STAGE_W * N_STG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             mode_wide,
  input  logic             wr_strobe,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             start_req,
  output logic             ser_out,
  output logic             busy,
  output logic             done
);
  logic load_ev;
  logic tick_ev;
  logic flush_ev;
  logic mode_lat;
  logic last_pos;

  wsel_tx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_strobe (wr_strobe),
    .start_req (start_req),
    .shift_en  (shift_en),
    .mode_in   (mode_wide),
    .at_last   (last_pos),
    .load      (load_ev),
    .tick      (tick_ev),
    .flush     (flush_ev),
    .mode_q    (mode_lat),
    .busy      (busy),
    .done      (done)
  );

  wsel_bit_counter #(.STAGE_W(STAGE_W), .N_STG(N_STG)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (tick_ev),
    .wide    (mode_lat),
    .at_last (last_pos)
  );

  wsel_shift_chain #(.STAGE_W(STAGE_W), .N_STG(N_STG)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_ev),
    .load_word (wr_data),
    .tick      (tick_ev),
    .flush     (flush_ev),
    .wide      (mode_lat),
    .ser_q     (ser_out)
  );

  // R10: pin is quiet whenever no frame is running
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_out);
  // R5: an idle start request makes the block busy
  p_busy_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_req) |=> busy);
endmodule

// File: tb/wsel_serial_tx_tb.sv
module wsel_serial_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shift_en = 1'b0;
  logic        mode_wide = 1'b0;
  logic        wr_strobe = 1'b0;
  logic [15:0] wr_data = '0;
  logic        start_req = 1'b0;
  logic        ser_out, busy, done;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          finished = 1'b0;

  always #5ns clk = ~clk;

  wsel_serial_tx dut_i (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .mode_wide(mode_wide),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .start_req(start_req),
    .ser_out(ser_out), .busy(busy), .done(done)
  );

  function automatic int unsigned bits_in_frame(input bit wide);
    return wide ? 16 : 8;
  endfunction

  function automatic bit nth_bit(input logic [15:0] w, input int unsigned k);
    return bit'((int'(w) / (1 << k)) % 2);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) shift_en = 1'b1;
    @(negedge clk) shift_en = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] w);
    @(negedge clk) begin wr_strobe = 1'b1; wr_data = w; end
    @(negedge clk) wr_strobe = 1'b0;
  endtask

  // disturbance during a frame: write, start and mode flip (R7, R8, R9)
  task automatic disturb();
    @(negedge clk) begin
      wr_strobe = 1'b1; wr_data = 16'($urandom); start_req = 1'b1;
      mode_wide = ~mode_wide;
    end
    @(negedge clk) begin
      wr_strobe = 1'b0; start_req = 1'b0; mode_wide = ~mode_wide;
    end
  endtask

  task automatic run_frame(input logic [15:0] w, input bit wide,
                           input string req, input bit mess);
    int unsigned n;
    logic prev;
    n = bits_in_frame(wide);
    @(negedge clk) begin mode_wide = wide; start_req = 1'b1; end
    @(negedge clk) start_req = 1'b0;
    chk("R5", "busy after start", 16'(busy), 16'd1);
    chk("R5", "pin before first tick", 16'(ser_out), 16'd0);
    for (int unsigned k = 0; k < n; k++) begin
      prev = ser_out;
      if (mess && k == 3) disturb();
      repeat ($urandom_range(0, 3)) @(negedge clk);
      if (k > 0) chk("R4", "hold between ticks", 16'(ser_out), 16'(prev));
      do_tick();
      chk(req, $sformatf("bit %0d", k), 16'(ser_out), 16'(nth_bit(w, k)));
    end
    chk("R6", "busy through last bit", 16'(busy), 16'd1);
    do_tick();
    chk("R6", "busy after tail", 16'(busy), 16'd0);
    chk("R10", "pin idle", 16'(ser_out), 16'd0);
    chk("R6", "done pulse", 16'(done), 16'd1);
    @(negedge clk);
    chk("R6", "done single", 16'(done), 16'd0);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk("R1", "ser_out reset", 16'(ser_out), 16'd0);
    chk("R1", "busy reset", 16'(busy), 16'd0);
    chk("R1", "done reset", 16'(done), 16'd0);
    @(negedge clk) rst_n = 1'b1;

    do_load(16'h7234);
    run_frame(16'h7234, 1'b1, "R2", 1'b0);
    do_load(16'h7234);
    run_frame(16'h0034, 1'b0, "R3", 1'b0);
    // no new load: low stage refilled with zeros, upper byte retained (R3)
    run_frame(16'h7200, 1'b1, "R3", 1'b0);
    // idle load then frame disturbed by write/start/mode (R7, R8, R9)
    do_load(16'hA5C3);
    run_frame(16'hA5C3, 1'b1, "R7", 1'b1);
    do_load(16'h3C96);
    run_frame(16'h0096, 1'b0, "R8", 1'b1);
    run_frame(16'h3C00, 1'b1, "R9", 1'b0);

    for (int i = 0; i < 24; i++) begin
      logic [15:0] w;
      bit wd;
      w  = 16'($urandom);
      wd = bit'($urandom_range(0, 1));
      do_load(w);
      run_frame(wd ? w : {8'h00, w[7:0]}, wd, wd ? "R2" : "R3",
                bit'($urandom_range(0, 1)));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule